// File: doc/BRIEF.md
# UART Receiver with Multiprocessor Address Filtering

This block receives asynchronous serial frames on a single line and decides whether each received byte should raise the receive-complete flag. It takes a 16x oversampling enable from an external baud generator, confirms a start bit at mid-bit, and shifts in eight data bits with the least significant bit first. In the 9-bit modes it also shifts in a ninth bit. It then samples the stop bit. In the 8-bit mode the stop bit serves as the ninth bit.

When multiprocessor filtering is enabled, only address frames (ninth bit high) raise the flag, and only if the byte matches this device's masked address or its broadcast pattern. The masked address has don't-care positions wherever the mask holds a zero. The broadcast pattern is the OR of the address and the mask; a bit that is zero in both is don't-care, and every other bit must be one. While the flag is still set from an earlier frame, the data register is held. Software clears the flag through a clear strobe. A separate mode bit makes a low stop-bit sample set a sticky framing-error flag.

The state machine has five states. IDLE waits for a low line on a tick. START counts to mid-bit and either confirms (START→DATA) or rejects a false start (START→IDLE). DATA samples eight bits at the middle of each bit. After the last bit it moves DATA→NINTH in the 9-bit modes and DATA→STOP in the 8-bit mode. NINTH samples the ninth bit and moves NINTH→STOP. STOP samples the stop bit, makes the filtering decision and returns STOP→IDLE. Mode 0 forces every state back to IDLE.

Top module: `mpc_rx_filter`

## Requirements
- R1: After reset, `ri`, `fe`, `rx_bit9` and `rx_data` are all zero.
- R2: A low line that is high again at the mid-bit sample (8th tick after detection) is a false start: the block returns to IDLE, loads nothing and receives the next valid frame correctly.
- R3: Frame layout: a low start bit, eight data bits LSB first, then a ninth bit only when `mode[1]`=1 (modes 2 and 3), then a stop bit. `rx_bit9` takes the ninth bit in modes 2 and 3 and the stop bit in mode 1.
- R4: With `mp_en`=0, every frame whose stop bit samples high loads `rx_data`/`rx_bit9` and sets `ri`; a frame with a low stop bit sets no `ri`.
- R5: With `mp_en`=1 in modes 2 and 3, a frame whose ninth bit is 0 leaves `ri` and `rx_data` unchanged.
- R6: With `mp_en`=1, an address frame is accepted when `(rx ^ own_addr) & addr_mask` is zero; a mask bit of 0 is don't-care.
- R7: With `mp_en`=1, an address frame is accepted when every bit that is 1 in `own_addr | addr_mask` is also 1 in the received byte.
- R8: In mode 1 with `mp_en`=1, `ri` is set only when the address matches and the stop bit is high.
- R9: In mode 0 (`mode`=2'b00) the receiver stays idle and loads nothing, whatever `mp_en` holds.
- R10: With `fe_view`=1, a low stop-bit sample sets `fe`; with `fe_view`=0, `fe` never sets; `fe_clr` clears `fe`.
- R11: While `ri` is set, a new frame changes neither `rx_data` nor `rx_bit9`.
- R12: `ri_clr` clears `ri` on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rxd | input | 1 | Serial receive line, idle high |
| tick16 | input | 1 | One-cycle enable at 16x the bit rate |
| mode | input | 2 | 0 off, 1 eight-bit, 2/3 nine-bit |
| mp_en | input | 1 | Multiprocessor address filtering enable |
| fe_view | input | 1 | Low stop bit sets `fe` when 1 |
| own_addr | input | W | Individual device address |
| addr_mask | input | W | Address mask, zero bits are don't-care |
| ri_clr | input | 1 | Clear strobe for `ri` |
| fe_clr | input | 1 | Clear strobe for `fe` |
| rx_data | output | W | Last accepted byte |
| rx_bit9 | output | 1 | Ninth bit (stop bit in mode 1) of last accepted frame |
| ri | output | 1 | Receive-complete flag |
| fe | output | 1 | Sticky framing-error flag |

## Verification
The assertions assume that `mode`, `mp_en` and `fe_view` stay constant while a frame is in flight. They also assume that `tick16` is a single-cycle pulse, so each tick advances the oversample counter exactly once. The stimulus changes the configuration only between frames, after the line has been idle for a full bit time. It drives `tick16` from a fixed divider. Each bit is held for sixteen ticks and starts at a free phase relative to the tick, so mid-bit sampling is exercised with real skew.

// File: rtl/mpc_rx_pkg.sv
package mpc_rx_pkg;
    typedef enum logic [2:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_NINTH,
        RX_STOP
    } rx_state_e;
endpackage

// File: rtl/mpc_addr_match.sv
module mpc_addr_match #(
    parameter int unsigned W = 8
) (
    input  logic [W-1:0] rx_byte,
    input  logic [W-1:0] own,
    input  logic [W-1:0] mask,
    output logic         hit
);
    logic [W-1:0] bc_pat;
    logic         hit_given;
    logic         hit_bcast;

    always_comb begin
        bc_pat    = own | mask;
        hit_given = ((rx_byte ^ own) & mask) == '0;
        hit_bcast = ((~rx_byte) & bc_pat) == '0;
        hit       = hit_given | hit_bcast;
    end
endmodule

// File: rtl/mpc_rx_fsm.sv
module mpc_rx_fsm
    import mpc_rx_pkg::*;
#(
    parameter int unsigned W   = 8,
    parameter int unsigned OSR = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         rxd_s,
    input  logic         en,
    input  logic         nine_bit,
    output logic         frame_done,
    output logic [W-1:0] rx_byte,
    output logic         bit9,
    output logic         stop_bit
);
    localparam int unsigned CW  = $clog2(OSR);
    localparam int unsigned IW  = $clog2(W);
    localparam int unsigned MID = OSR / 2 - 1;

    rx_state_e      state, nxt;
    logic [CW-1:0]  os_cnt;
    logic [IW-1:0]  bit_idx;
    logic [W-1:0]   shreg;
    logic           bit9_r;
    logic           os_last;
    logic           os_mid;

    assign os_last = tick && (os_cnt == CW'(OSR - 1));
    assign os_mid  = tick && (os_cnt == CW'(MID));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= RX_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            RX_IDLE:  if (en && tick && !rxd_s) nxt = RX_START;
            RX_START: if (!en) nxt = RX_IDLE;
                      else if (os_mid) nxt = rxd_s ? RX_IDLE : RX_DATA;
            RX_DATA:  if (!en) nxt = RX_IDLE;
                      else if (os_last && bit_idx == IW'(W - 1))
                          nxt = nine_bit ? RX_NINTH : RX_STOP;
            RX_NINTH: if (!en) nxt = RX_IDLE;
                      else if (os_last) nxt = RX_STOP;
            RX_STOP:  if (!en || os_last) nxt = RX_IDLE;
            default:  nxt = RX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            os_cnt  <= '0;
            bit_idx <= '0;
            shreg   <= '0;
            bit9_r  <= 1'b0;
        end else begin
            if (state != nxt)
                os_cnt <= '0;
            else if (tick)
                os_cnt <= (os_cnt == CW'(OSR - 1)) ? '0 : os_cnt + 1'b1;
            if (state == RX_START)
                bit_idx <= '0;
            else if (state == RX_DATA && os_last) begin
                shreg   <= {rxd_s, shreg[W-1:1]};
                bit_idx <= bit_idx + 1'b1;
            end
            if (state == RX_NINTH && os_last)
                bit9_r <= rxd_s;
        end
    end

    always_comb begin
        frame_done = en && (state == RX_STOP) && os_last;
        rx_byte    = shreg;
        bit9       = bit9_r;
        stop_bit   = rxd_s;
    end

    // R2
    false_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == RX_START && en && os_mid && rxd_s) |=> (state == RX_IDLE));

    // R9
    rx_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (state == RX_IDLE));
endmodule

// File: rtl/mpc_rx_filter.sv
module mpc_rx_filter #(
    parameter int unsigned W   = 8,
    parameter int unsigned OSR = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         rxd,
    input  logic         tick16,
    input  logic [1:0]   mode,
    input  logic         mp_en,
    input  logic         fe_view,
    input  logic [W-1:0] own_addr,
    input  logic [W-1:0] addr_mask,
    input  logic         ri_clr,
    input  logic         fe_clr,
    output logic [W-1:0] rx_data,
    output logic         rx_bit9,
    output logic         ri,
    output logic         fe
);
    logic [1:0]   sync_q;
    logic         rx_en;
    logic         nine_bit;
    logic         frame_done;
    logic [W-1:0] got_byte;
    logic         got_bit9;
    logic         got_stop;
    logic         ninth;
    logic         addr_hit;
    logic         accept;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= 2'b11;
        else        sync_q <= {sync_q[0], rxd};
    end

    assign rx_en    = (mode != 2'b00);
    assign nine_bit = mode[1];

    mpc_rx_fsm #(.W(W), .OSR(OSR)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick16),
        .rxd_s      (sync_q[1]),
        .en         (rx_en),
        .nine_bit   (nine_bit),
        .frame_done (frame_done),
        .rx_byte    (got_byte),
        .bit9       (got_bit9),
        .stop_bit   (got_stop)
    );

    mpc_addr_match #(.W(W)) u_match (
        .rx_byte (got_byte),
        .own     (own_addr),
        .mask    (addr_mask),
        .hit     (addr_hit)
    );

    always_comb begin
        ninth  = nine_bit ? got_bit9 : got_stop;
        accept = frame_done && got_stop && !ri && (!mp_en || (ninth && addr_hit));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_data <= '0;
            rx_bit9 <= 1'b0;
            ri      <= 1'b0;
            fe      <= 1'b0;
        end else begin
            if (accept) begin
                rx_data <= got_byte;
                rx_bit9 <= ninth;
                ri      <= 1'b1;
            end else if (ri_clr) begin
                ri <= 1'b0;
            end
            if (frame_done && fe_view && !got_stop) fe <= 1'b1;
            else if (fe_clr)                        fe <= 1'b0;
        end
    end

    // R11
    held_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ri |=> ($stable(rx_data) && $stable(rx_bit9)));

    // R12
    ri_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ri && ri_clr) |=> !ri);

    // R10
    fe_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!fe_view && !fe) |=> !fe);

    // R5
    data_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_done && mp_en && nine_bit && !got_bit9 && !ri_clr)
            |=> ($stable(ri) && $stable(rx_data)));
endmodule

// File: tb/mpc_rx_filter_bench.sv
module mpc_rx_filter_bench;
    localparam int unsigned W   = 8;
    localparam int BIT_CLKS     = 64;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         rxd = 1'b1;
    logic         tick16 = 1'b0;
    logic [1:0]   mode = 2'd1;
    logic         mp_en = 1'b0;
    logic         fe_view = 1'b0;
    logic [W-1:0] own_addr = 8'h56;
    logic [W-1:0] addr_mask = 8'hFC;
    logic         ri_clr = 1'b0;
    logic         fe_clr = 1'b0;
    logic [W-1:0] rx_data;
    logic         rx_bit9;
    logic         ri;
    logic         fe;

    int total = 0;
    int bad = 0;
    int tdiv = 0;
    bit cmp_en = 1'b0;
    string cur_req = "R1";

    logic [W-1:0] m_data = '0;
    logic         m_bit9 = 1'b0;
    logic         m_ri = 1'b0;
    logic         m_fe = 1'b0;

    mpc_rx_filter #(.W(W), .OSR(16)) u_mpc_rx_filter (
        .clk(clk), .rst_n(rst_n), .rxd(rxd), .tick16(tick16), .mode(mode),
        .mp_en(mp_en), .fe_view(fe_view), .own_addr(own_addr),
        .addr_mask(addr_mask), .ri_clr(ri_clr), .fe_clr(fe_clr),
        .rx_data(rx_data), .rx_bit9(rx_bit9), .ri(ri), .fe(fe)
    );

    always #4 clk = ~clk;

    always @(posedge clk) begin
        tdiv   <= (tdiv == 3) ? 0 : tdiv + 1;
        tick16 <= (tdiv == 3);
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic check_all(input string req);
        chk(ri == m_ri, {req, " ri"}, int'(ri), int'(m_ri));
        chk(rx_data == m_data, {req, " rx_data"}, int'(rx_data), int'(m_data));
        chk(rx_bit9 == m_bit9, {req, " rx_bit9"}, int'(rx_bit9), int'(m_bit9));
        chk(fe == m_fe, {req, " fe"}, int'(fe), int'(m_fe));
    endtask

    // per-clock comparison against the model while no update is in flight
    always @(negedge clk) begin
        #1;
        if (cmp_en) check_all(cur_req);
    end

    task automatic drive_bit(input logic v);
        @(negedge clk) rxd = v;
        repeat (BIT_CLKS - 1) @(negedge clk);
    endtask

    task automatic send_frame(input logic [W-1:0] d, input logic d8, input logic stp,
                              input string req);
        logic ninth;
        bit   given_ok;
        bit   bc_ok;
        bit   acc;
        cmp_en = 1'b0;
        drive_bit(1'b0);
        for (int i = 0; i < W; i++) drive_bit(d[i]);
        if (mode[1]) drive_bit(d8);
        drive_bit(stp);
        drive_bit(1'b1);
        if (mode != 2'd0) begin
            ninth    = mode[1] ? d8 : stp;
            given_ok = 1'b1;
            bc_ok    = 1'b1;
            for (int i = 0; i < W; i++) begin
                if (addr_mask[i] && (d[i] != own_addr[i])) given_ok = 1'b0;
                if ((own_addr[i] || addr_mask[i]) && !d[i]) bc_ok = 1'b0;
            end
            acc = stp && !m_ri && (!mp_en || (ninth && (given_ok || bc_ok)));
            if (acc) begin
                m_data = d;
                m_bit9 = ninth;
                m_ri   = 1'b1;
            end
            if (fe_view && !stp) m_fe = 1'b1;
        end
        cur_req = req;
        check_all(req);
        cmp_en = 1'b1;
    endtask

    task automatic clear_ri();
        cmp_en = 1'b0;
        @(negedge clk) ri_clr = 1'b1;
        @(negedge clk) ri_clr = 1'b0;
        m_ri = 1'b0;
        #1;
        chk(ri == 1'b0, "R12 ri after clear", int'(ri), 0);
        cmp_en = 1'b1;
    endtask

    task automatic clear_fe();
        cmp_en = 1'b0;
        @(negedge clk) fe_clr = 1'b1;
        @(negedge clk) fe_clr = 1'b0;
        m_fe = 1'b0;
        #1;
        chk(fe == 1'b0, "R10 fe after clear", int'(fe), 0);
        cmp_en = 1'b1;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        check_all("R1");
        rst_n = 1'b1;
        repeat (8) @(negedge clk);
        cmp_en = 1'b1;

        // R3 R4: mode 1, no filtering
        send_frame(8'hA5, 1'b0, 1'b1, "R4 mode1 plain");
        // R11: flag still set, new byte must not overwrite
        send_frame(8'h3C, 1'b0, 1'b1, "R11 held");
        clear_ri();

        // R3: nine-bit layout, ninth bit lands in rx_bit9
        mode = 2'd3;
        send_frame(8'h5A, 1'b0, 1'b1, "R3 mode3 ninth0");
        clear_ri();
        send_frame(8'h11, 1'b1, 1'b0, "R4 low stop");

        // R5 R6 R7: filtering in mode 2
        mode  = 2'd2;
        mp_en = 1'b1;
        send_frame(8'h55, 1'b1, 1'b1, "R6 given match");
        clear_ri();
        send_frame(8'h5A, 1'b1, 1'b1, "R6 given miss");
        send_frame(8'h56, 1'b0, 1'b1, "R5 data frame");
        send_frame(8'hFF, 1'b1, 1'b1, "R7 broadcast FF");
        clear_ri();
        send_frame(8'hFE, 1'b1, 1'b1, "R7 broadcast FE");
        clear_ri();
        send_frame(8'hFD, 1'b1, 1'b1, "R7 broadcast miss");

        // R8 R10: mode 1 with filtering, stop bit as ninth
        mode = 2'd1;
        send_frame(8'h57, 1'b0, 1'b1, "R8 mode1 match");
        clear_ri();
        send_frame(8'h57, 1'b0, 1'b0, "R8 R10 low stop quiet");
        fe_view = 1'b1;
        send_frame(8'h57, 1'b0, 1'b0, "R10 fe set");
        clear_fe();
        fe_view = 1'b0;

        // R9: mode 0 ignores the line even with filtering on
        mode = 2'd0;
        send_frame(8'h56, 1'b1, 1'b1, "R9 mode0");

        // R2: short low pulse, then a valid frame
        mode   = 2'd1;
        mp_en  = 1'b0;
        cmp_en = 1'b0;
        @(negedge clk) rxd = 1'b0;
        repeat (12) @(negedge clk);
        rxd = 1'b1;
        repeat (2 * BIT_CLKS) @(negedge clk);
        #1;
        chk(ri == 1'b0, "R2 false start ri", int'(ri), 0);
        chk(rx_data == m_data, "R2 false start data", int'(rx_data), int'(m_data));
        cmp_en = 1'b1;
        send_frame(8'h81, 1'b0, 1'b1, "R2 after false start");
        clear_ri();

        cmp_en = 1'b0;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule